// File: doc/BRIEF.md
# Coprocessor Trap Sequencer

This block carries out a software coprocessor-emulation trap for an 8-bit accumulator-style CPU core. The fetch stage presents an opcode, its operand byte, the return address, the status byte and the stack pointer, and pulses `start`. If the opcode is one of the two trap opcodes, the sequencer captures that context and raises `busy` to stall fetch. It then runs a fixed microsequence over a single byte-wide synchronous memory bus and finishes by loading the program counter.

The trap has two forms, each with its own opcode. The immediate form takes the operand byte as a selector. The zero-page form uses the operand as a zero-page address and reads the selector from memory. The selector is loaded into the X index register, or into the accumulator when `LOAD_TO_X` is 0. The selector lets the handler jump through an indexed table at once.

The sequencer then saves state the way a software break does. It pushes the return address and the status byte, then adjusts the flags. Last, it reads a dedicated two-byte vector and jumps through it.

Top module: `cop_trap_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `busy`, `done` and every bus and load strobe are low.
- R2: A `start` pulse in the idle state whose opcode matches neither `OPC_IMM` (default 0x02) nor `OPC_ZP` (default 0x42) has no effect: `busy` stays low and no strobe is raised.
- R3: For `OPC_IMM`, in the first cycle after `start` is accepted, the X load strobe is high and `reg_data` equals the captured operand byte.
- R4: For `OPC_ZP`, in the first cycle after acceptance, a read is issued at address {0x00, operand}. In the next cycle the X load strobe is high and `reg_data` equals the byte returned by that read.
- R5: After the selector load, three writes to page 0x01 follow on consecutive cycles. The first puts the return-address high byte at {0x01, sp}, the second puts the low byte at {0x01, sp-1}, and the third puts the status byte with bit 4 (break) forced to 1 at {0x01, sp-2}. The low address byte wraps modulo 256. Each write raises `ld_sp` with `sp_out` equal to the written offset minus one.
- R6: In the cycle of the status push, `ld_p` is high and `p_out` is the captured status with bit 2 (interrupt disable) set and bit 3 (decimal) cleared. This happens before the first vector read.
- R7: The two cycles after the status push read address 0xFFE6 and then 0xFFE7. In the following cycle `ld_pc` is high and `pc_out` is {byte read from 0xFFE7, byte read from 0xFFE6}.
- R8: `busy` is high from the first cycle after acceptance through the `ld_pc` cycle. `done` is high in exactly that `ld_pc` cycle, and `busy` is low in the next one. The whole trap takes 7 busy cycles in the immediate form and 8 in the zero-page form.
- R9: `start` and all context inputs are ignored while `busy` is high. The running sequence uses only the values captured at acceptance.
- R10: With `LOAD_TO_X` = 0 the selector load raises `ld_a` instead of `ld_x`, with the same data and timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Fetch stage presents an instruction this cycle |
| opcode | input | 8 | Opcode of the presented instruction |
| operand | input | 8 | Immediate selector or zero-page address |
| pc_ret | input | 16 | Return address to push |
| status_in | input | 8 | Current status byte |
| sp_in | input | 8 | Current stack pointer |
| busy | output | 1 | Trap in progress, fetch stalled |
| done | output | 1 | Last trap cycle, PC loaded |
| mem_addr | output | 16 | Memory bus address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_re` |
| ld_x | output | 1 | Load X with `reg_data` |
| ld_a | output | 1 | Load accumulator with `reg_data` |
| reg_data | output | 8 | Selector byte |
| ld_sp | output | 1 | Load stack pointer with `sp_out` |
| sp_out | output | 8 | New stack pointer |
| ld_p | output | 1 | Load status with `p_out` |
| p_out | output | 8 | New status byte |
| ld_pc | output | 1 | Load program counter with `pc_out` |
| pc_out | output | 16 | Vector target |

## Verification
The assertions take three things for granted. Reset is low from time zero. `mem_rdata` carries the addressed byte exactly one cycle after a read strobe. The context inputs are meaningful in the cycle `start` is sampled. The bench keeps to these rules with a memory model that registers a computed byte for every read, and with a reset held from the first instant. It drives inputs only at falling edges. The bench also scrambles the context inputs and re-pulses `start` in the middle of each trap, to show that only the captured values matter.

// File: rtl/cop_trap_pkg.sv
// Shared types for the coprocessor trap sequencer.
// Assumes a byte-wide data path; the state list fixes the microsequence order.
package cop_trap_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ZPRD,
        ST_OPLD,
        ST_PUSHH,
        ST_PUSHL,
        ST_PUSHP,
        ST_VECL,
        ST_VECH,
        ST_JUMP
    } cop_state_e;

endpackage

// File: rtl/cop_trap_ctrl.sv
// Microsequence controller: recognises the two trap opcodes while idle and
// steps through the fixed state list. It assumes the datapath captures the
// context in the same cycle that `accept` is high.
module cop_trap_ctrl
    import cop_trap_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter logic [DATA_W-1:0] OPC_IMM = 8'h02,
    parameter logic [DATA_W-1:0] OPC_ZP  = 8'h42
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] opcode,
    output cop_state_e        state,
    output logic              accept,
    output logic              accept_zp
);

    cop_state_e state_nx;

    // Opcode match is only honoured in the idle state.
    always_comb begin
        accept_zp = start && (opcode == OPC_ZP);
        accept    = (state == ST_IDLE) && start &&
                    ((opcode == OPC_IMM) || (opcode == OPC_ZP));
    end

    // Next-state selection along the fixed trap sequence.
    always_comb begin
        case (state)
            ST_IDLE:  state_nx = accept ? (accept_zp ? ST_ZPRD : ST_OPLD) : ST_IDLE;
            ST_ZPRD:  state_nx = ST_OPLD;
            ST_OPLD:  state_nx = ST_PUSHH;
            ST_PUSHH: state_nx = ST_PUSHL;
            ST_PUSHL: state_nx = ST_PUSHP;
            ST_PUSHP: state_nx = ST_VECL;
            ST_VECL:  state_nx = ST_VECH;
            ST_VECH:  state_nx = ST_JUMP;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // R8: once started, the sequence never falls back to idle early.
    p_seq_progress_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_JUMP) |=> (state != ST_IDLE));

endmodule

// File: rtl/cop_trap_dpath.sv
// Trap datapath: holds the captured context, the working stack pointer and
// the low vector byte, and decodes the state into bus and load strobes.
// It assumes read data arrives one cycle after a read strobe.
module cop_trap_dpath
    import cop_trap_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [2*DATA_W-1:0] VEC_BASE = 16'hFFE6,
    parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
    parameter int                BRK_BIT    = 4,
    parameter int                IRQ_BIT    = 2,
    parameter int                DEC_BIT    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cop_state_e          state,
    input  logic                accept,
    input  logic                accept_zp,
    input  logic [DATA_W-1:0]   operand,
    input  logic [2*DATA_W-1:0] pc_ret,
    input  logic [DATA_W-1:0]   status_in,
    input  logic [DATA_W-1:0]   sp_in,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                mem_we,
    output logic                mem_re,
    output logic [DATA_W-1:0]   mem_wdata,
    output logic                sel_ld,
    output logic [DATA_W-1:0]   sel_val,
    output logic                sp_ld,
    output logic [DATA_W-1:0]   sp_val,
    output logic                p_ld,
    output logic [DATA_W-1:0]   p_val,
    output logic                pc_ld,
    output logic [2*DATA_W-1:0] pc_val
);

    localparam int                ADDR_W   = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] VEC_HI   = VEC_BASE + ADDR_W'(1);
    localparam logic [DATA_W-1:0] BRK_MASK = DATA_W'(1) << BRK_BIT;
    localparam logic [DATA_W-1:0] IRQ_MASK = DATA_W'(1) << IRQ_BIT;
    localparam logic [DATA_W-1:0] DEC_MASK = DATA_W'(1) << DEC_BIT;

    logic [ADDR_W-1:0] ctx_pc;
    logic [DATA_W-1:0] ctx_p;
    logic [DATA_W-1:0] ctx_opnd;
    logic              ctx_zp;
    logic [DATA_W-1:0] sp_q;
    logic [DATA_W-1:0] vec_lo;
    logic              pushing;

    // Capture the instruction context at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_pc   <= '0;
            ctx_p    <= '0;
            ctx_opnd <= '0;
            ctx_zp   <= 1'b0;
        end else if (accept) begin
            ctx_pc   <= pc_ret;
            ctx_p    <= status_in;
            ctx_opnd <= operand;
            ctx_zp   <= accept_zp;
        end
    end

    // Working stack pointer: loaded at acceptance, decremented per push.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp_q <= '0;
        else if (accept)  sp_q <= sp_in;
        else if (pushing) sp_q <= sp_q - DATA_W'(1);
    end

    // Hold the low vector byte until the high byte returns.
    always_ff @(posedge clk) begin
        if (!rst_n)                 vec_lo <= '0;
        else if (state == ST_VECH)  vec_lo <= mem_rdata;
    end

    // Bus strobes decoded from the state.
    always_comb begin
        pushing = (state == ST_PUSHH) || (state == ST_PUSHL) || (state == ST_PUSHP);
        mem_we  = pushing;
        mem_re  = (state == ST_ZPRD) || (state == ST_VECL) || (state == ST_VECH);
    end

    // Bus address and write data per state.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_ZPRD:  mem_addr = {{DATA_W{1'b0}}, ctx_opnd};
            ST_PUSHH: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = ctx_pc[ADDR_W-1:DATA_W];
            end
            ST_PUSHL: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = ctx_pc[DATA_W-1:0];
            end
            ST_PUSHP: begin
                mem_addr  = {STACK_PAGE, sp_q};
                mem_wdata = ctx_p | BRK_MASK;
            end
            ST_VECL:  mem_addr = VEC_BASE;
            ST_VECH:  mem_addr = VEC_HI;
            default:  mem_addr = '0;
        endcase
    end

    // Register-file and program-counter load values.
    always_comb begin
        sel_ld  = (state == ST_OPLD);
        sel_val = ctx_zp ? mem_rdata : ctx_opnd;
        sp_ld   = pushing;
        sp_val  = sp_q - DATA_W'(1);
        p_ld    = (state == ST_PUSHP);
        p_val   = (ctx_p | IRQ_MASK) & ~DEC_MASK;
        pc_ld   = (state == ST_JUMP);
        pc_val  = {mem_rdata, vec_lo};
    end

    // R5: the pushed status byte always carries the break flag.
    p_brk_pushed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && p_ld) |-> mem_wdata[BRK_BIT]);

    // R6: new status has interrupts masked and decimal mode off.
    p_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        p_ld |-> (p_val[IRQ_BIT] && !p_val[DEC_BIT]));

endmodule

// File: rtl/cop_trap_seq.sv
// Coprocessor trap sequencer top: ties the controller to the datapath and
// routes the selector load to X or the accumulator by parameter.
// It assumes a single-port synchronous byte bus with one-cycle read latency.
module cop_trap_seq
    import cop_trap_pkg::*;
#(
    parameter int        DATA_W     = 8,
    parameter logic [7:0] OPC_IMM   = 8'h02,
    parameter logic [7:0] OPC_ZP    = 8'h42,
    parameter logic [15:0] VEC_BASE = 16'hFFE6,
    parameter logic [7:0] STACK_PAGE = 8'h01,
    parameter bit        LOAD_TO_X  = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  opcode,
    input  logic [7:0]  operand,
    input  logic [15:0] pc_ret,
    input  logic [7:0]  status_in,
    input  logic [7:0]  sp_in,
    output logic        busy,
    output logic        done,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        ld_x,
    output logic        ld_a,
    output logic [7:0]  reg_data,
    output logic        ld_sp,
    output logic [7:0]  sp_out,
    output logic        ld_p,
    output logic [7:0]  p_out,
    output logic        ld_pc,
    output logic [15:0] pc_out
);

    cop_state_e state;
    logic       accept;
    logic       accept_zp;
    logic       sel_ld;

    cop_trap_ctrl #(
        .DATA_W  (DATA_W),
        .OPC_IMM (OPC_IMM),
        .OPC_ZP  (OPC_ZP)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .opcode    (opcode),
        .state     (state),
        .accept    (accept),
        .accept_zp (accept_zp)
    );

    cop_trap_dpath #(
        .DATA_W     (DATA_W),
        .VEC_BASE   (VEC_BASE),
        .STACK_PAGE (STACK_PAGE)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .accept    (accept),
        .accept_zp (accept_zp),
        .operand   (operand),
        .pc_ret    (pc_ret),
        .status_in (status_in),
        .sp_in     (sp_in),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .sel_ld    (sel_ld),
        .sel_val   (reg_data),
        .sp_ld     (ld_sp),
        .sp_val    (sp_out),
        .p_ld      (ld_p),
        .p_val     (p_out),
        .pc_ld     (ld_pc),
        .pc_val    (pc_out)
    );

    // Status outputs toward the fetch stage.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_JUMP);
    end

    // Destination register chosen at elaboration.
    generate
        if (LOAD_TO_X) begin : g_sel_to_x
            assign ld_x = sel_ld;
            assign ld_a = 1'b0;
        end else begin : g_sel_to_a
            assign ld_x = 1'b0;
            assign ld_a = sel_ld;
        end
    endgenerate

    // R8: done coincides with the PC load while still busy.
    p_done_with_pc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ld_pc && busy));

    // R8: fetch is released right after done.
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R2: an unknown opcode in idle does not start a trap.
    p_ignore_other_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && opcode != OPC_IMM && opcode != OPC_ZP) |=> !busy);

    // R5: every write lands in the stack page.
    p_stack_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == STACK_PAGE));

    // R5: back-to-back pushes walk down one byte at a time.
    p_push_descend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1));

    // R5: reads and writes never share a cycle.
    p_bus_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    // R6: flags are updated in the cycle before the first vector read.
    p_flags_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && mem_addr == VEC_BASE) |-> $past(ld_p));

    // R7: the PC load follows the high vector read.
    p_vec_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_pc |-> ($past(mem_re) && $past(mem_addr) == VEC_BASE + 16'd1));

endmodule

// File: tb/tb_cop_trap_seq.sv
`timescale 1ns/1ps
module tb_cop_trap_seq;

    localparam logic [7:0] OPC_IMM = 8'h02;
    localparam logic [7:0] OPC_ZP  = 8'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] opcode = 8'h00, operand = 8'h00, status_in = 8'h00, sp_in = 8'h00;
    logic [15:0] pc_ret = 16'h0000;

    logic busy, done, mem_we, mem_re, ld_x, ld_a, ld_sp, ld_p, ld_pc;
    logic [15:0] mem_addr, pc_out;
    logic [7:0] mem_wdata, reg_data, sp_out, p_out;
    logic [7:0] mem_rdata = 8'h00;

    logic a_busy, a_done, a_we, a_re, a_ldx, a_lda, a_ldsp, a_ldp, a_ldpc;
    logic [15:0] a_addr, a_pc;
    logic [7:0] a_wdata, a_reg, a_sp, a_p;
    logic [7:0] a_rdata = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        logic [7:0] h;
        h = a[15:8];
        return (h * 8'd7) ^ a[7:0] ^ 8'hC3;
    endfunction

    // Memory models with one-cycle read latency.
    always_ff @(posedge clk) if (mem_re) mem_rdata <= memf(mem_addr);
    always_ff @(posedge clk) if (a_re)   a_rdata   <= memf(a_addr);

    cop_trap_seq #(.OPC_IMM(OPC_IMM), .OPC_ZP(OPC_ZP)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .pc_ret(pc_ret), .status_in(status_in), .sp_in(sp_in),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_x(ld_x), .ld_a(ld_a),
        .reg_data(reg_data), .ld_sp(ld_sp), .sp_out(sp_out), .ld_p(ld_p), .p_out(p_out),
        .ld_pc(ld_pc), .pc_out(pc_out)
    );

    cop_trap_seq #(.OPC_IMM(OPC_IMM), .OPC_ZP(OPC_ZP), .LOAD_TO_X(1'b0)) dut_acc (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .pc_ret(pc_ret), .status_in(status_in), .sp_in(sp_in),
        .busy(a_busy), .done(a_done), .mem_addr(a_addr), .mem_we(a_we), .mem_re(a_re),
        .mem_wdata(a_wdata), .mem_rdata(a_rdata), .ld_x(a_ldx), .ld_a(a_lda),
        .reg_data(a_reg), .ld_sp(a_ldsp), .sp_out(a_sp), .ld_p(a_ldp), .p_out(a_p),
        .ld_pc(a_ldpc), .pc_out(a_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] strobes();
        return {busy, done, mem_we, mem_re, ld_x, ld_a, ld_sp, ld_p, ld_pc};
    endfunction

    // One trap; every cycle is compared with the computed timeline.
    task automatic run_one(input bit zp, input logic [7:0] op, input logic [15:0] pc,
                           input logic [7:0] st, input logic [7:0] sp);
        int z;
        logic [7:0] sel;
        logic [15:0] vec;
        z   = zp ? 1 : 0;
        sel = zp ? memf({8'h00, op}) : op;
        vec = {memf(16'hFFE7), memf(16'hFFE6)};
        @(negedge clk);
        start = 1'b1; opcode = zp ? OPC_ZP : OPC_IMM; operand = op;
        pc_ret = pc; status_in = st; sp_in = sp;
        for (int c = 1; c <= 8 + z; c++) begin
            bit e_re, e_we, e_ld, e_p, e_pc, e_busy;
            @(negedge clk);
            e_re   = (zp && c == 1) || (c == 5 + z) || (c == 6 + z);
            e_we   = (c >= 2 + z) && (c <= 4 + z);
            e_ld   = (c == 1 + z);
            e_p    = (c == 4 + z);
            e_pc   = (c == 7 + z);
            e_busy = (c <= 7 + z);
            // R8 timeline, R3/R4 load strobe placement.
            chk("R8 strobe timeline", {23'd0, strobes()},
                {23'd0, e_busy, e_pc, e_we, e_re, e_ld, 1'b0, e_we, e_p, e_pc});
            chk("R10 acc variant strobes", {29'd0, a_ldx, a_lda, a_busy}, {29'd0, 1'b0, e_ld, e_busy});
            if (zp && c == 1) chk("R4 zero-page read address", {16'd0, mem_addr}, {24'd0, op});
            if (e_ld) begin
                chk(zp ? "R4 zp selector" : "R3 imm selector", {24'd0, reg_data}, {24'd0, sel});
                chk("R10 acc selector", {24'd0, a_reg}, {24'd0, sel});
            end
            if (e_we) begin
                logic [7:0] off, wd;
                off = sp - 8'(c - 2 - z);
                wd  = (c == 2 + z) ? pc[15:8] : (c == 3 + z) ? pc[7:0] : (st | 8'h10);
                chk("R5 push address", {16'd0, mem_addr}, {16'd0, 8'h01, off});
                chk("R5 push data", {24'd0, mem_wdata}, {24'd0, wd});
                chk("R5 sp update", {24'd0, sp_out}, {24'd0, off - 8'd1});
            end
            if (e_p)  chk("R6 new status", {24'd0, p_out}, {24'd0, (st | 8'h04) & 8'hF7});
            if (c == 5 + z) chk("R7 low vector address", {16'd0, mem_addr}, 32'h0000FFE6);
            if (c == 6 + z) chk("R7 high vector address", {16'd0, mem_addr}, 32'h0000FFE7);
            if (e_pc) chk("R7 vector target", {16'd0, pc_out}, {16'd0, vec});
            // R9: scramble context and re-pulse start while busy.
            start = (c == 3); opcode = OPC_IMM; operand = ~op;
            pc_ret = ~pc; status_in = ~st; sp_in = ~sp;
        end
        start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {23'd0, strobes()}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobes after reset", {23'd0, strobes()}, 32'd0);

        // R2: every opcode other than the two trap opcodes is ignored.
        for (int o = 0; o < 256; o++) begin
            if (8'(o) == OPC_IMM || 8'(o) == OPC_ZP) continue;
            start = 1'b1; opcode = 8'(o); operand = 8'(o);
            @(negedge clk);
            start = 1'b0;
            chk("R2 unknown opcode ignored", {23'd0, strobes()}, 32'd0);
        end

        // R3-R10: every operand in both forms, stack pointer swept incl. wrap.
        for (int o = 0; o < 256; o++) begin
            for (int f = 0; f < 2; f++) begin
                run_one(f == 1, 8'(o), {8'(o) ^ 8'hA5, ~8'(o)}, 8'(o * 37), 8'(o + f));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule